// File: doc/BRIEF.md
# Slot-Based Custom Instruction Execute Unit

This block sits beside the integer ALU in the execute stage of a small CPU. Opcodes that the base instruction set leaves unused are treated as custom instructions. Both register operands and an eight-bit control field go to a row of five identical instruction slots at the same time. Every slot returns its own 32-bit result and four flags. A final wide multiplexer picks either the normal ALU result or the output of one slot.

A small placement table is loaded through a write port. Each entry says which custom identifier is present, at which slot it starts, how many adjacent slots it covers, and which function the loaded module provides. The result of a multi-slot instruction is always read from its start slot. The operand wiring interleaves across the row, so odd-numbered slots see the two operands in swapped order. Non-commutative functions undo that swap, so software gets the same answer wherever the module is placed. Three example functions are provided: a one-bit XOR reduction over both operands, a signed saturating add/subtract, and a one-byte CRC-16 step.

Operands are captured on the first clock edge after issue. The result is registered on the next edge.

Top module: `cix_exec`

## Requirements
- R1: When an issued opcode is below 0x30, the block returns the ALU result and ALU flags that were presented with it, and `undef_o` stays low.
- R2: `res_valid_o` is high exactly two rising edges after a cycle in which `issue_i` was high, and low at every other time.
- R3: A table write is accepted only if its start is below 5, its span is at least 1, and start plus span is at most 5. Any other write leaves the table unchanged.
- R4: For an issued opcode from 0x30 to 0x3F, the identifier is the opcode minus 0x30. The lowest-numbered valid table entry with that identifier gives the start slot, and the result and flags come from that slot. The function at a slot is the function of the lowest-numbered valid entry that starts there.
- R5: If a custom opcode matches no valid entry, `undef_o` is 1 and both the result and the flags are 0.
- R6: Function code 1 returns, in bit 0, the XOR of all 64 operand bits. All other result bits are 0.
- R7: Function code 2 returns A+B, or A−B when control bit 0 is set. Both values are signed 32-bit. The result is clamped to 0x7FFFFFFF or 0x80000000 on overflow.
- R8: Function code 3 treats A[15:0] as a CRC register and B[7:0] as a data byte. It applies polynomial 0x1021 with the most significant bit first and returns the new register in bits 15:0, with the upper bits 0.
- R9: A custom instruction gives the same result whether its start slot is odd or even.
- R10: The flags of a custom result are: bit 0 = result is zero, bit 1 = result bit 31, bit 2 = the saturating function clamped, bit 3 = 0.
- R11: After reset the table is empty, `res_valid_o` is 0, and the result, flags and `undef_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 6 | Instruction opcode |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| ctrl_i | input | 8 | Control field sent to the slots; bit 0 selects subtract |
| alu_res_i | input | 32 | Result from the base ALU |
| alu_flags_i | input | 4 | Flags from the base ALU |
| tbl_we_i | input | 1 | Placement table write strobe |
| tbl_sel_i | input | 2 | Table entry to write |
| tbl_valid_i | input | 1 | Valid bit of the written entry |
| tbl_id_i | input | 4 | Custom identifier of the written entry |
| tbl_start_i | input | 3 | Start slot of the written entry |
| tbl_span_i | input | 3 | Number of slots covered |
| tbl_func_i | input | 2 | Loaded function: 0 none, 1 XOR, 2 saturate, 3 CRC |
| res_valid_o | output | 1 | Result valid |
| res_o | output | 32 | Selected result |
| flags_o | output | 4 | Selected flags |
| undef_o | output | 1 | Custom opcode with no placed instruction |

## Verification
The hardest case is a non-commutative function at an odd start slot. A fault in the alignment swap stays hidden for symmetric inputs and for any module placed on an even slot. The stimulus therefore moves each function across every legal start slot, with operands where A and B differ strongly: overflow corners for subtraction, and distinct CRC register and data values. It also chains nine CRC steps through the output at both an odd and an even placement, and compares the final value with the known check value for the ASCII digits 1 to 9. Overlapping identifiers, rejected writes and a random mixed burst cover the priority and table rules.

// File: rtl/cix_pkg.sv
package cix_pkg;

    localparam int CIX_DATA_W = 32;
    localparam int CIX_FLAG_W = 4;
    localparam int CIX_CTRL_W = 8;
    localparam int CIX_NSLOT  = 5;
    localparam int CIX_NENT   = 4;
    localparam int CIX_ID_W   = 4;
    localparam int CIX_OPC_W  = 6;
    localparam int CIX_SLOT_W = $clog2(CIX_NSLOT + 1);
    localparam logic [CIX_OPC_W-1:0] CIX_CUST_BASE = 6'h30;
    localparam int CIX_CRC_W  = 16;
    localparam logic [CIX_CRC_W-1:0] CIX_CRC_POLY = 16'h1021;

    typedef enum logic [1:0] {
        FN_NONE = 2'd0,
        FN_XOR  = 2'd1,
        FN_SAT  = 2'd2,
        FN_CRC  = 2'd3
    } func_e;

    typedef struct packed {
        logic                  valid;
        logic [CIX_ID_W-1:0]   id;
        logic [CIX_SLOT_W-1:0] start;
        logic [CIX_SLOT_W-1:0] span;
        func_e                 func;
    } place_t;

    typedef struct packed {
        logic  active;
        func_e func;
    } slot_cfg_t;

    // returns {clamped, value}
    function automatic logic [CIX_DATA_W:0] sat_addsub(
        input logic [CIX_DATA_W-1:0] a,
        input logic [CIX_DATA_W-1:0] b,
        input logic                  sub
    );
        logic [CIX_DATA_W:0] wide;
        logic [CIX_DATA_W:0] out;
        if (sub) wide = {a[CIX_DATA_W-1], a} - {b[CIX_DATA_W-1], b};
        else     wide = {a[CIX_DATA_W-1], a} + {b[CIX_DATA_W-1], b};
        if (wide[CIX_DATA_W] != wide[CIX_DATA_W-1]) begin
            if (wide[CIX_DATA_W]) out = {1'b1, 1'b1, {(CIX_DATA_W-1){1'b0}}};
            else                  out = {1'b1, 1'b0, {(CIX_DATA_W-1){1'b1}}};
        end else begin
            out = {1'b0, wide[CIX_DATA_W-1:0]};
        end
        return out;
    endfunction

    function automatic logic [CIX_CRC_W-1:0] crc_byte(
        input logic [CIX_CRC_W-1:0] reg_in,
        input logic [7:0]           data
    );
        logic [CIX_CRC_W-1:0] r;
        logic                 fb;
        r = reg_in;
        for (int i = 7; i >= 0; i--) begin
            fb = r[CIX_CRC_W-1] ^ data[i];
            r  = {r[CIX_CRC_W-2:0], 1'b0} ^ (fb ? CIX_CRC_POLY : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/cix_slot_table.sv
module cix_slot_table
    import cix_pkg::*;
#(
    parameter int NENT  = CIX_NENT,
    parameter int NSLOT = CIX_NSLOT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [$clog2(NENT)-1:0] wsel_i,
    input  place_t                 wentry_i,
    input  logic [CIX_ID_W-1:0]    qid_i,
    output logic                   hit_o,
    output logic [CIX_SLOT_W-1:0]  hstart_o,
    output slot_cfg_t              cfg_o [NSLOT]
);

    typedef struct packed {
        place_t [NENT-1:0] ent;
    } tbl_st_t;

    tbl_st_t st_d, st_q;
    logic    wr_ok;

    always_comb begin
        wr_ok = (int'(wentry_i.start) < NSLOT) && (wentry_i.span != '0) &&
                (int'(wentry_i.start) + int'(wentry_i.span) <= NSLOT);
        st_d = st_q;
        if (we_i && wr_ok) st_d.ent[wsel_i] = wentry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // identifier lookup, lowest entry index wins
    always_comb begin
        hit_o    = 1'b0;
        hstart_o = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (st_q.ent[i].valid && st_q.ent[i].id == qid_i) begin
                hit_o    = 1'b1;
                hstart_o = st_q.ent[i].start;
            end
        end
    end

    // which function each slot currently hosts
    for (genvar s = 0; s < NSLOT; s++) begin : g_cfg
        always_comb begin
            cfg_o[s] = '0;
            for (int i = NENT - 1; i >= 0; i--) begin
                if (st_q.ent[i].valid && st_q.ent[i].start == CIX_SLOT_W'(s)) begin
                    cfg_o[s].active = 1'b1;
                    cfg_o[s].func   = st_q.ent[i].func;
                end
            end
        end
    end

    a_r3_start_out_of_row: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(wentry_i.start) >= NSLOT) |=> $stable(st_q));

    a_r3_zero_span: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wentry_i.span == '0) |=> $stable(st_q));

    a_r3_single_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wentry_i.start == '0 && wentry_i.span == CIX_SLOT_W'(1))
        |=> (st_q.ent[$past(wsel_i)] == $past(wentry_i)));

endmodule

// File: rtl/cix_slot.sv
module cix_slot
    import cix_pkg::*;
#(
    parameter int DATA_W      = CIX_DATA_W,
    parameter int FLAG_W      = CIX_FLAG_W,
    parameter int CTRL_W      = CIX_CTRL_W,
    parameter int IDX         = 0,
    parameter bit ODD_VARIANT = 1'b0
) (
    input  logic [DATA_W-1:0] bus_a_i,
    input  logic [DATA_W-1:0] bus_b_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  slot_cfg_t         cfg_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o
);

    localparam bit ODD = IDX[0];

    logic [DATA_W-1:0] phys_a, phys_b;
    logic [DATA_W-1:0] sat_a, sat_b, crc_a, crc_b;
    logic [DATA_W:0]   sat_w;
    logic              clamp;
    logic              ctrl_unused;

    // interleaved operand routing: odd slots see the pair swapped
    assign phys_a = ODD ? bus_b_i : bus_a_i;
    assign phys_b = ODD ? bus_a_i : bus_b_i;
    assign ctrl_unused = ^ctrl_i[CTRL_W-1:1];

    if (ODD && !ODD_VARIANT) begin : g_align
        logic need_swap;
        assign need_swap = (cfg_i.func == FN_SAT) || (cfg_i.func == FN_CRC);
        assign sat_a = need_swap ? phys_b : phys_a;
        assign sat_b = need_swap ? phys_a : phys_b;
        assign crc_a = need_swap ? phys_b : phys_a;
        assign crc_b = need_swap ? phys_a : phys_b;
    end else if (ODD) begin : g_odd_variant
        assign sat_a = phys_b;
        assign sat_b = phys_a;
        assign crc_a = phys_b;
        assign crc_b = phys_a;
    end else begin : g_even
        assign sat_a = phys_a;
        assign sat_b = phys_b;
        assign crc_a = phys_a;
        assign crc_b = phys_b;
    end

    always_comb begin
        res_o   = '0;
        clamp   = 1'b0;
        sat_w   = sat_addsub(sat_a, sat_b, ctrl_i[0]);
        if (cfg_i.active) begin
            unique case (cfg_i.func)
                FN_XOR:  res_o = {{(DATA_W-1){1'b0}}, ^{phys_a, phys_b}};
                FN_SAT: begin
                    res_o = sat_w[DATA_W-1:0];
                    clamp = sat_w[DATA_W];
                end
                FN_CRC:  res_o = {{(DATA_W-CIX_CRC_W){1'b0}},
                                  crc_byte(crc_a[CIX_CRC_W-1:0], crc_b[7:0])};
                default: res_o = '0;
            endcase
        end
        if (cfg_i.active && cfg_i.func != FN_NONE)
            flags_o = {1'b0, clamp, res_o[DATA_W-1], res_o == '0};
        else
            flags_o = '0;
    end

    always_comb begin
        if (!cfg_i.active)
            a_r4_idle_slot_quiet: assert (res_o == '0 && flags_o == '0);
        if (flags_o[2])
            a_r7_clamp_at_limit: assert (res_o == {1'b1, {(DATA_W-1){1'b0}}} ||
                                         res_o == {1'b0, {(DATA_W-1){1'b1}}});
    end

endmodule

// File: rtl/cix_exec.sv
module cix_exec
    import cix_pkg::*;
#(
    parameter int DATA_W      = CIX_DATA_W,
    parameter int FLAG_W      = CIX_FLAG_W,
    parameter int CTRL_W      = CIX_CTRL_W,
    parameter int NSLOT       = CIX_NSLOT,
    parameter int NENT        = CIX_NENT,
    parameter bit ODD_VARIANT = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_i,
    input  logic [CIX_OPC_W-1:0]    opcode_i,
    input  logic [DATA_W-1:0]       opa_i,
    input  logic [DATA_W-1:0]       opb_i,
    input  logic [CTRL_W-1:0]       ctrl_i,
    input  logic [DATA_W-1:0]       alu_res_i,
    input  logic [FLAG_W-1:0]       alu_flags_i,
    input  logic                    tbl_we_i,
    input  logic [$clog2(NENT)-1:0] tbl_sel_i,
    input  logic                    tbl_valid_i,
    input  logic [CIX_ID_W-1:0]     tbl_id_i,
    input  logic [CIX_SLOT_W-1:0]   tbl_start_i,
    input  logic [CIX_SLOT_W-1:0]   tbl_span_i,
    input  logic [1:0]              tbl_func_i,
    output logic                    res_valid_o,
    output logic [DATA_W-1:0]       res_o,
    output logic [FLAG_W-1:0]       flags_o,
    output logic                    undef_o
);

    typedef struct packed {
        logic                s1_vld;
        logic                s1_cust;
        logic [CIX_ID_W-1:0] s1_id;
        logic [DATA_W-1:0]   s1_a;
        logic [DATA_W-1:0]   s1_b;
        logic [CTRL_W-1:0]   s1_ctrl;
        logic [DATA_W-1:0]   s1_alu;
        logic [FLAG_W-1:0]   s1_aluf;
        logic                o_vld;
        logic                o_cust;
        logic [DATA_W-1:0]   o_res;
        logic [FLAG_W-1:0]   o_flags;
        logic                o_undef;
    } exe_st_t;

    exe_st_t st_d, st_q;

    place_t                wentry;
    logic                  hit;
    logic [CIX_SLOT_W-1:0] hstart;
    slot_cfg_t             cfg [NSLOT];
    logic [DATA_W-1:0]     slot_res [NSLOT];
    logic [FLAG_W-1:0]     slot_fl  [NSLOT];
    logic [DATA_W-1:0]     sel_res;
    logic [FLAG_W-1:0]     sel_fl;

    assign wentry = '{valid: tbl_valid_i, id: tbl_id_i, start: tbl_start_i,
                      span: tbl_span_i, func: func_e'(tbl_func_i)};

    cix_slot_table #(.NENT(NENT), .NSLOT(NSLOT)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (tbl_we_i),
        .wsel_i   (tbl_sel_i),
        .wentry_i (wentry),
        .qid_i    (st_q.s1_id),
        .hit_o    (hit),
        .hstart_o (hstart),
        .cfg_o    (cfg)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        cix_slot #(
            .DATA_W(DATA_W), .FLAG_W(FLAG_W), .CTRL_W(CTRL_W),
            .IDX(s), .ODD_VARIANT(ODD_VARIANT)
        ) u_slot (
            .bus_a_i (st_q.s1_a),
            .bus_b_i (st_q.s1_b),
            .ctrl_i  (st_q.s1_ctrl),
            .cfg_i   (cfg[s]),
            .res_o   (slot_res[s]),
            .flags_o (slot_fl[s])
        );
    end

    // instruction select multiplexer over the slot row
    always_comb begin
        sel_res = '0;
        sel_fl  = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (hstart == CIX_SLOT_W'(s)) begin
                sel_res = slot_res[s];
                sel_fl  = slot_fl[s];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.s1_vld = issue_i;
        if (issue_i) begin
            st_d.s1_cust = (opcode_i >= CIX_CUST_BASE);
            st_d.s1_id   = CIX_ID_W'(opcode_i - CIX_CUST_BASE);
            st_d.s1_a    = opa_i;
            st_d.s1_b    = opb_i;
            st_d.s1_ctrl = ctrl_i;
            st_d.s1_alu  = alu_res_i;
            st_d.s1_aluf = alu_flags_i;
        end
        st_d.o_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.o_cust = st_q.s1_cust;
            if (!st_q.s1_cust) begin
                st_d.o_res   = st_q.s1_alu;
                st_d.o_flags = st_q.s1_aluf;
                st_d.o_undef = 1'b0;
            end else if (hit) begin
                st_d.o_res   = sel_res;
                st_d.o_flags = sel_fl;
                st_d.o_undef = 1'b0;
            end else begin
                st_d.o_res   = '0;
                st_d.o_flags = '0;
                st_d.o_undef = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o = st_q.o_vld;
    assign res_o       = st_q.o_res;
    assign flags_o     = st_q.o_flags;
    assign undef_o     = st_q.o_undef;

    a_r2_result_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> ##1 res_valid_o);

    a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ##1 !res_valid_o);

    a_r5_undef_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && undef_o) |-> (res_o == '0 && flags_o == '0));

    a_r1_base_never_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !st_q.o_cust) |-> !undef_o);

    a_r10_top_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && st_q.o_cust) |-> !flags_o[FLAG_W-1]);

endmodule

// File: tb/sim_cix_exec.sv
module sim_cix_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0, alu_res_i = '0;
    logic [7:0]  ctrl_i = '0;
    logic [3:0]  alu_flags_i = '0;
    logic        tbl_we_i = 1'b0, tbl_valid_i = 1'b0;
    logic [1:0]  tbl_sel_i = '0, tbl_func_i = '0;
    logic [3:0]  tbl_id_i = '0;
    logic [2:0]  tbl_start_i = '0, tbl_span_i = '0;
    logic        res_valid_o, undef_o;
    logic [31:0] res_o;
    logic [3:0]  flags_o;

    always #4 clk = ~clk;

    cix_exec u0 (.*);

    typedef struct {
        int          due;
        logic [31:0] res;
        logic [3:0]  fl;
        logic        undef;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0, fails = 0, cyc = 0;
    int   m_valid[4], m_id[4], m_start[4], m_span[4], m_func[4];
    bit   done = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick();
        exp_t e;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            check(res_valid_o === 1'b1, {e.tag, " valid R2"}, 64'(res_valid_o), 64'd1);
            check(res_o === e.res, {e.tag, " result"}, 64'(res_o), 64'(e.res));
            check(flags_o === e.fl, {e.tag, " flags R10"}, 64'(flags_o), 64'(e.fl));
            check(undef_o === e.undef, {e.tag, " undef R5"}, 64'(undef_o), 64'(e.undef));
        end else begin
            check(res_valid_o === 1'b0, "R2 idle valid", 64'(res_valid_o), 64'd0);
        end
    endtask

    task automatic idle(input int n);
        issue_i = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    function automatic exp_t model(input logic [5:0] op, input logic [31:0] a, b,
                                   input logic [7:0] ctl, input logic [31:0] alu,
                                   input logic [3:0] af);
        exp_t e;
        int hit = -1, owner = -1;
        longint sa, sb, r;
        bit sat = 0;
        e.undef = 0;
        if (op < 6'h30) begin
            e.res = alu; e.fl = af;
            return e;
        end
        for (int i = 3; i >= 0; i--)
            if (m_valid[i] != 0 && m_id[i] == int'(op) - 48) hit = i;
        if (hit < 0) begin
            e.res = 0; e.fl = 0; e.undef = 1;
            return e;
        end
        for (int i = 3; i >= 0; i--)
            if (m_valid[i] != 0 && m_start[i] == m_start[hit]) owner = i;
        case (m_func[owner])
            1: e.res = {31'd0, ^{a, b}};
            2: begin
                sa = longint'($signed(a));
                sb = longint'($signed(b));
                r  = ctl[0] ? sa - sb : sa + sb;
                if (r > 64'sd2147483647)       begin e.res = 32'h7FFFFFFF; sat = 1; end
                else if (r < -64'sd2147483648) begin e.res = 32'h80000000; sat = 1; end
                else e.res = r[31:0];
            end
            3: e.res = {16'd0, ref_crc(a[15:0], b[7:0])};
            default: e.res = 0;
        endcase
        if (m_func[owner] == 0) e.fl = 0;
        else e.fl = {1'b0, sat, e.res[31], e.res == 0};
        return e;
    endfunction

    task automatic issue(input logic [5:0] op, input logic [31:0] a, b,
                         input logic [7:0] ctl, input string tag);
        exp_t e;
        logic [31:0] alu = $urandom;
        logic [3:0]  af  = 4'($urandom);
        issue_i = 1'b1; opcode_i = op; opa_i = a; opb_i = b; ctrl_i = ctl;
        alu_res_i = alu; alu_flags_i = af;
        e = model(op, a, b, ctl, alu, af);
        e.due = cyc + 2;
        e.tag = tag;
        q.push_back(e);
        tick();
    endtask

    task automatic place(input int sel, vld, id, start, span, func);
        tbl_we_i = 1'b1; tbl_sel_i = 2'(sel); tbl_valid_i = 1'(vld); tbl_id_i = 4'(id);
        tbl_start_i = 3'(start); tbl_span_i = 3'(span); tbl_func_i = 2'(func);
        if (start < 5 && span >= 1 && start + span <= 5) begin
            m_valid[sel] = vld; m_id[sel] = id; m_start[sel] = start;
            m_span[sel] = span; m_func[sel] = func;
        end
        tick();
        tbl_we_i = 1'b0;
    endtask

    task automatic crc_chain(input int start, input string tag);
        logic [15:0] c = 16'hFFFF;
        place(0, 1, 3, start, 2, 3);
        for (int k = 0; k < 9; k++) begin
            issue(6'h33, {16'hA5A5, c}, {24'h5A5A5A, 8'(8'h31 + k)}, 8'h00, tag);
            idle(1);
            c = res_o[15:0];
        end
        check(c == 16'h29B1, {tag, " check value R8 R9"}, 64'(c), 64'h29B1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired, R2 actual=hung expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 0; m_id[i] = 0; m_start[i] = 0; m_span[i] = 0; m_func[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        check(res_valid_o === 1'b0, "R11 valid in reset", 64'(res_valid_o), 0);
        check(res_o === '0 && flags_o === '0, "R11 outputs in reset", 64'(res_o), 0);
        check(undef_o === 1'b0, "R11 undef in reset", 64'(undef_o), 0);
        rst_n = 1'b1;
        idle(2);
        // R11/R5: table empty after reset
        issue(6'h30, 32'h1, 32'h2, 8'h0, "R11 empty table");
        issue(6'h3F, 32'h3, 32'h4, 8'h0, "R5 unmatched id");
        // R1 base opcodes back to back
        for (int i = 0; i < 6; i++) issue(6'(i * 9), $urandom, $urandom, 8'($urandom), "R1 base op");
        idle(3);
        // R4 R6 R7 R8 R9: each function at every legal start slot
        for (int f = 1; f <= 3; f++) begin
            for (int s = 0; s < 5; s++) begin
                if (f == 3 && s > 3) continue;
                place(0, 1, f + 4, s, (f == 3) ? 2 : 1, f);
                idle(1);
                issue(6'(48 + f + 4), 32'h7FFFFFFF, 32'h00000001, 8'h00, "R7 R9 pos overflow");
                issue(6'(48 + f + 4), 32'h80000000, 32'h00000001, 8'h01, "R7 R9 neg overflow");
                issue(6'(48 + f + 4), 32'h00000010, 32'h00000003, 8'h01, "R7 R9 sub order");
                issue(6'(48 + f + 4), 32'h00000005, 32'h00000005, 8'h01, "R10 zero result");
                issue(6'(48 + f + 4), 32'h00001D0F, 32'h000000C3, 8'hFE, "R8 R9 crc step");
                issue(6'(48 + f + 4), 32'hF0F0F0F0, 32'h00000001, 8'h00, "R6 xor odd");
                for (int k = 0; k < 4; k++)
                    issue(6'(48 + f + 4), $urandom, $urandom, 8'($urandom), "R4 R9 random");
                idle(3);
            end
        end
        // R8 R9: chained CRC through the port at even and odd placement
        crc_chain(0, "R8 even start");
        crc_chain(1, "R9 odd start");
        idle(2);
        // R4 priority between entries sharing an id
        place(0, 1, 9, 1, 1, 1);
        place(1, 1, 9, 3, 1, 2);
        issue(6'h39, 32'h0000000F, 32'h00000001, 8'h00, "R4 lowest entry wins");
        idle(2);
        place(0, 0, 9, 1, 1, 1);
        issue(6'h39, 32'h0000000F, 32'h00000001, 8'h00, "R4 next entry after invalidate");
        idle(2);
        // R3 rejected writes keep entry 1 (saturate at slot 3)
        place(1, 1, 9, 5, 1, 1);
        issue(6'h39, 32'h7FFFFFF0, 32'h00000100, 8'h00, "R3 start out of row");
        idle(2);
        place(1, 1, 9, 2, 0, 3);
        issue(6'h39, 32'h7FFFFFF0, 32'h00000100, 8'h00, "R3 zero span");
        idle(2);
        place(1, 1, 9, 3, 3, 1);
        issue(6'h39, 32'h7FFFFFF0, 32'h00000100, 8'h00, "R3 span past row end");
        idle(2);
        // mixed burst
        place(0, 1, 1, 0, 1, 1);
        place(1, 1, 2, 1, 1, 2);
        place(2, 1, 3, 2, 2, 3);
        place(3, 1, 4, 4, 1, 2);
        idle(1);
        for (int i = 0; i < 60; i++) begin
            logic [5:0] op = ($urandom % 4 == 0) ? 6'($urandom % 48) : 6'(48 + $urandom % 6);
            issue(op, $urandom, $urandom, 8'($urandom), "R4 R5 mixed burst");
        end
        idle(4);
        check(q.size() == 0, "R2 all results seen", 64'(q.size()), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule